// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This block keeps the eight-bit status word of a serial non-volatile memory and rules on every write that reaches it. It carries a write-enable latch, a busy flag for the self-timed write cycle, a two-bit protection level that fences off an upper slice of the array, and a lock bit. The lock bit combines with an active-low protect pin to freeze the status word itself.

The command decoder in front of the block sends it one-cycle strobes. These set or clear the enable latch, request a status write with the new byte and the number of data bits clocked in before chip select rose, or request an array write at an address. The unit reports the status word for reads. It also reports whether the current address falls in the fenced region and whether an array or status write would be taken now. It runs the write-cycle timer, which holds the busy flag high for a fixed number of clocks.

Top module: `sr_protect_unit`

## Requirements
- R1: `status_o` is packed with the lock bit at bit 7, zeros at bits 6 to 4, the protection level (high, low) at bits 3 and 2, the enable latch at bit 1 and the busy flag at bit 0.
- R2: After reset the status word is 0x00, `busy_o` is 0 and no address is protected.
- R3: A `wel_set_i` pulse sets the enable latch and a `wel_clr_i` pulse clears it. When both arrive in the same cycle, clear wins.
- R4: A status write is taken only when `sr_wr_bits_i` equals 8, the enable latch is 1, the unit is idle and the lock mode is off. A request that fails any of these leaves the status word and `busy_o` unchanged.
- R5: A taken status write raises `busy_o` for exactly `WR_CYCLES` clocks. Until it ends, bits 7, 3 and 2 keep their old values. When it ends, they take bits 7, 3 and 2 of the written byte. Bits 1 and 0 never follow the written byte.
- R6: The end of any write cycle, status or array, clears the enable latch.
- R7: Protection level 00 guards no address. Level 01 guards the top quarter (0xC000–0xFFFF for 16 bits), level 10 the top half (0x8000–0xFFFF), and level 11 every address.
- R8: Lock mode holds while bit 7 is 1 and `wp_ni` is low, whichever became true first. In lock mode, status writes are refused even with the enable latch set. Raising `wp_ni` ends lock mode at once.
- R9: Status or array write requests that arrive while `busy_o` is 1 are ignored.
- R10: `arr_wr_ok_o` is 1 only when the enable latch is 1, the unit is idle and `addr_i` is unguarded. An array write request starts a write cycle only in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wp_ni | input | 1 | Active-low protect pin |
| wel_set_i | input | 1 | Set pulse for the enable latch |
| wel_clr_i | input | 1 | Clear pulse for the enable latch |
| sr_wr_req_i | input | 1 | Status write request, one cycle, at chip-select rise |
| sr_wr_bits_i | input | SR_BITS_W | Data bits clocked in before chip select rose |
| sr_wr_data_i | input | 8 | New status byte |
| arr_wr_req_i | input | 1 | Array write request, one cycle |
| addr_i | input | ADDR_W | Array address under test |
| status_o | output | 8 | Status word |
| addr_prot_o | output | 1 | `addr_i` lies in the guarded region |
| arr_wr_ok_o | output | 1 | An array write would be taken now |
| sr_wr_ok_o | output | 1 | A well-framed status write would be taken now |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The assertions assume that every request and latch strobe is a single-cycle pulse, synchronous to the clock, and that `wp_ni` changes only between clock edges. They also assume the timer is started only from idle, which the top-level gating ensures. The bench drives every input on the falling edge and returns each strobe to zero one cycle later. It never holds a strobe across a cycle boundary. It moves the protect pin only between requests, so no check depends on a pin change in the same cycle as a request.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;
   localparam int SR_DATA_BITS = 8;
   localparam int SR_LOCK_BIT  = 7;
   localparam int SR_LVL_HI    = 3;
   localparam int SR_LVL_LO    = 2;

   typedef enum logic [1:0] {
      PROT_NONE    = 2'b00,
      PROT_QUARTER = 2'b01,
      PROT_HALF    = 2'b10,
      PROT_ALL     = 2'b11
   } prot_lvl_e;

   typedef enum logic {
      CYC_ARRAY  = 1'b0,
      CYC_STATUS = 1'b1
   } cyc_kind_e;

   typedef struct packed {
      logic      lock;
      prot_lvl_e lvl;
   } prot_cfg_t;
endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode
   import sr_wp_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  prot_lvl_e         lvl_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam int TOP = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_width
      $error("sr_prot_decode: ADDR_W must be at least 2");
   end

   logic top_quarter;
   logic top_half;

   assign top_quarter = addr_i[TOP] & addr_i[TOP-1];
   assign top_half    = addr_i[TOP];

   always_comb begin
      unique case (lvl_i)
         PROT_NONE:    hit_o = 1'b0;
         PROT_QUARTER: hit_o = top_quarter;
         PROT_HALF:    hit_o = top_half;
         default:      hit_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/sr_cycle_timer.sv
module sr_cycle_timer #(
   parameter int CYCLES = 100
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("sr_cycle_timer: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

   // R5: a start from idle raises the busy flag on the next edge
   assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_q) |=> busy_o);
endmodule

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic wel_o
);
   logic wel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    wel_q <= 1'b0;
      else if (clr_i) wel_q <= 1'b0;
      else if (set_i) wel_q <= 1'b1;
   end

   assign wel_o = wel_q;

   // R3: clear has priority
   assert_clear_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !wel_o);
   // R3: a lone set takes effect
   assert_set_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !clr_i) |=> wel_o);
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
   import sr_wp_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WR_CYCLES = 100,
   parameter int SR_BITS_W = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wp_ni,
   input  logic                 wel_set_i,
   input  logic                 wel_clr_i,
   input  logic                 sr_wr_req_i,
   input  logic [SR_BITS_W-1:0] sr_wr_bits_i,
   input  logic [7:0]           sr_wr_data_i,
   input  logic                 arr_wr_req_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [7:0]           status_o,
   output logic                 addr_prot_o,
   output logic                 arr_wr_ok_o,
   output logic                 sr_wr_ok_o,
   output logic                 busy_o
);
   localparam logic [SR_BITS_W-1:0] FRAME_BITS = SR_BITS_W'(SR_DATA_BITS);

   if (SR_BITS_W < $clog2(SR_DATA_BITS + 1)) begin : g_bad_bits
      $error("sr_protect_unit: SR_BITS_W too narrow to count a data byte");
   end

   prot_cfg_t cfg_q;
   prot_cfg_t pend_q;
   cyc_kind_e kind_q;
   logic      wel;
   logic      busy;
   logic      done;
   logic      lock_mode;
   logic      sr_accept;
   logic      arr_accept;
   logic      wel_drop;

   sr_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
      .lvl_i  (cfg_q.lvl),
      .addr_i (addr_i),
      .hit_o  (addr_prot_o)
   );

   sr_cycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (sr_accept | arr_accept),
      .busy_o  (busy),
      .done_o  (done)
   );

   assign wel_drop = wel_clr_i | done;

   sr_wel_latch u_wel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wel_set_i),
      .clr_i  (wel_drop),
      .wel_o  (wel)
   );

   assign lock_mode   = cfg_q.lock & ~wp_ni;
   assign sr_wr_ok_o  = wel & ~busy & ~lock_mode;
   assign arr_wr_ok_o = wel & ~busy & ~addr_prot_o;
   assign sr_accept   = sr_wr_req_i & (sr_wr_bits_i == FRAME_BITS) & sr_wr_ok_o;
   assign arr_accept  = arr_wr_req_i & arr_wr_ok_o & ~sr_accept;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= '{lock: 1'b0, lvl: PROT_NONE};
         pend_q <= '{lock: 1'b0, lvl: PROT_NONE};
         kind_q <= CYC_ARRAY;
      end else begin
         if (sr_accept | arr_accept) begin
            pend_q.lock <= sr_wr_data_i[SR_LOCK_BIT];
            pend_q.lvl  <= prot_lvl_e'(sr_wr_data_i[SR_LVL_HI:SR_LVL_LO]);
            kind_q      <= sr_accept ? CYC_STATUS : CYC_ARRAY;
         end
         if (done && kind_q == CYC_STATUS) begin
            cfg_q <= pend_q;
         end
      end
   end

   assign status_o = {cfg_q.lock, 3'b000, cfg_q.lvl, wel, busy};
   assign busy_o   = busy;

   // R8: in lock mode an idle unit refuses a status write
   assert_lock_refuses_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sr_wr_req_i && cfg_q.lock && !wp_ni && !busy_o && !arr_wr_req_i) |=> !busy_o);
   // R5: protection fields change only when a status cycle ends
   assert_cfg_deferred_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cfg_q) |-> $past(done && kind_q == CYC_STATUS));
   // R6: the enable latch is low once a cycle has ended
   assert_wel_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> !status_o[1]);
   // R9: requests during a cycle leave the captured request untouched
   assert_busy_ignores_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && (sr_wr_req_i || arr_wr_req_i)) |=> $stable({pend_q, kind_q}));
   // R10: a guarded address never starts an array cycle
   assert_guard_array_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arr_wr_req_i && addr_prot_o && !busy_o && !sr_wr_req_i) |=> !busy_o);
endmodule

// File: tb/sim_sr_protect_unit.sv
module sim_sr_protect_unit;
   localparam int ADDR_W = 16;
   localparam int WRC    = 6;
   localparam int BW     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_n = 1'b1;
   logic              wset = 1'b0, wclr = 1'b0;
   logic              sreq = 1'b0, areq = 1'b0;
   logic [BW-1:0]     sbits = '0;
   logic [7:0]        sdata = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        status;
   logic              aprot, aok, sok, busy;

   int checks = 0;
   int errors = 0;
   logic done_flag = 1'b0;

   always #10 clk = ~clk;

   sr_protect_unit #(.ADDR_W(ADDR_W), .WR_CYCLES(WRC), .SR_BITS_W(BW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n),
      .wel_set_i(wset), .wel_clr_i(wclr),
      .sr_wr_req_i(sreq), .sr_wr_bits_i(sbits), .sr_wr_data_i(sdata),
      .arr_wr_req_i(areq), .addr_i(addr),
      .status_o(status), .addr_prot_o(aprot), .arr_wr_ok_o(aok),
      .sr_wr_ok_o(sok), .busy_o(busy)
   );

   // lvl[18:17], addr[16:1], expected guard[0]
   localparam logic [18:0] VEC [11] = '{
      {2'b00, 16'hFFFF, 1'b0}, {2'b01, 16'hBFFF, 1'b0}, {2'b01, 16'hC000, 1'b1},
      {2'b01, 16'hFFFF, 1'b1}, {2'b01, 16'h0000, 1'b0}, {2'b10, 16'h7FFF, 1'b0},
      {2'b10, 16'h8000, 1'b1}, {2'b10, 16'hC123, 1'b1}, {2'b11, 16'h0000, 1'b1},
      {2'b11, 16'h7FFF, 1'b1}, {2'b00, 16'h0000, 1'b0}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulse_set();
      @(negedge clk); wset = 1'b1;
      @(negedge clk); wset = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); wclr = 1'b1;
      @(negedge clk); wclr = 1'b0;
   endtask

   task automatic sr_req(input logic [7:0] d, input logic [BW-1:0] n);
      @(negedge clk); sreq = 1'b1; sdata = d; sbits = n;
      @(negedge clk); sreq = 1'b0;
   endtask

   task automatic wait_cycle();
      repeat (WRC) @(negedge clk);
   endtask

   task automatic program_sr(input logic [7:0] d);
      pulse_set();
      sr_req(d, BW'(8));
      wait_cycle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      addr = 16'hFFFF;
      chk("R2 status", {8'h0, status}, 16'h0000);
      chk("R2 busy", {15'h0, busy}, 16'h0);
      chk("R2 guard", {15'h0, aprot}, 16'h0);

      // R7 table walk
      for (int i = 0; i < 11; i++) begin
         if (status[3:2] != VEC[i][18:17])
            program_sr({4'b0000, VEC[i][18:17], 2'b00});
         addr = VEC[i][16:1];
         @(negedge clk);
         chk("R7 guard", {15'h0, aprot}, {15'h0, VEC[i][0]});
      end

      // R3 latch
      pulse_set();
      chk("R3 set", {8'h0, status}, 16'h0002);
      pulse_clr();
      chk("R3 clear", {8'h0, status}, 16'h0000);
      @(negedge clk); wset = 1'b1; wclr = 1'b1;
      @(negedge clk); wset = 1'b0; wclr = 1'b0;
      chk("R3 clear wins", {8'h0, status}, 16'h0000);

      // R4 refusals
      sr_req(8'h8C, BW'(8));
      chk("R4 no latch", {7'h0, busy, status}, 16'h0000);
      pulse_set();
      sr_req(8'h8C, BW'(7));
      chk("R4 seven bits", {7'h0, busy, status}, 16'h0002);
      sr_req(8'h8C, BW'(9));
      chk("R4 nine bits", {7'h0, busy, status}, 16'h0002);

      // R5 deferred update, R9 busy ignore, R6 latch drop, R1 layout
      sr_req(8'hFF, BW'(8));
      chk("R5 busy and old bits", {8'h0, status}, 16'h0003);
      sr_req(8'h00, BW'(8));
      repeat (WRC - 3) @(negedge clk);
      chk("R5 still busy", {8'h0, status}, 16'h0003);
      @(negedge clk);
      chk("R5 R6 R1 applied", {7'h0, busy, status}, 16'h008C);
      chk("R9 second request ignored", {8'h0, status[7:2], 2'b00}, 16'h008C);

      // R8 lock mode: lock bit first, pin low after
      wp_n = 1'b0;
      pulse_set();
      chk("R8 lock refuses ok", {15'h0, sok}, 16'h0);
      sr_req(8'h00, BW'(8));
      chk("R8 lock refuses", {7'h0, busy, status}, 16'h008E);
      wp_n = 1'b1;
      @(negedge clk);
      chk("R8 pin high releases", {15'h0, sok}, 16'h1);
      sr_req(8'h00, BW'(8));
      wait_cycle();
      chk("R8 write after release", {7'h0, busy, status}, 16'h0000);

      // R8 other order: pin low, then lock bit set
      wp_n = 1'b0;
      program_sr(8'h80);
      chk("R8 lock set with pin low", {8'h0, status}, 16'h0080);
      pulse_set();
      sr_req(8'h00, BW'(8));
      chk("R8 second order refuses", {7'h0, busy, status}, 16'h0082);
      wp_n = 1'b1;
      sr_req(8'h00, BW'(8));
      wait_cycle();
      chk("R8 restore", {8'h0, status}, 16'h0000);

      // R10 array permission
      addr = 16'h1234;
      @(negedge clk);
      chk("R10 no latch", {15'h0, aok}, 16'h0);
      pulse_set();
      chk("R10 open", {15'h0, aok}, 16'h1);
      @(negedge clk); areq = 1'b1;
      @(negedge clk); areq = 1'b0;
      chk("R10 array busy", {8'h0, status}, 16'h0003);
      chk("R9 array ok low while busy", {15'h0, aok}, 16'h0);
      wait_cycle();
      chk("R6 array end drops latch", {8'h0, status}, 16'h0000);
      program_sr(8'h0C);
      pulse_set();
      addr = 16'h0000;
      @(negedge clk);
      chk("R10 guarded ok", {15'h0, aok}, 16'h0);
      @(negedge clk); areq = 1'b1;
      @(negedge clk); areq = 1'b0;
      chk("R10 guarded refused", {7'h0, busy, status}, 16'h000E);

      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule